// File: doc/BRIEF.md
# Programmable-Rate Timestamp Counter

This block keeps a 64-bit time value that advances at a rate set by software. The rate is held in one 32-bit rate word. Its lower field is the step added to time, counted in sixteenths of a time unit. Its upper field is the number of base ticks between steps. A base tick is any clock cycle in which `base_tick` is high. Over one rate setting, time therefore grows by step/(16 × period) units per base tick. A zero period behaves as a period of one.

Internally the block adds the step into an accumulator that carries four fraction bits below the time unit. Reported time is an offset plus the integer part of that accumulator. The rate can be rewritten at any time. The accumulator is never rescaled, so a rate change only alters the slope from then on and never moves the reported value. A separate write adds a signed correction to the offset. A capture strobe copies the whole 64-bit time into a low word and a high word taken from the same instant.

The capture result is an output with no back-pressure. `cap_valid` pulses for one cycle after each strobe. The two words then hold until the next strobe, so a consumer may read them at any later time. Strobes are never refused or queued.

Top module: `tsc_timer`

## Requirements
- R1: After reset the captured words and `cap_valid` are zero. Accumulator, offset and rate word are all cleared, so time stays 0 even while base ticks arrive.
- R2: The rate word puts the step in bits 23:0 and the period in bits 31:24. A write takes effect for base ticks on the clock edges after the write edge. The write also restarts the period phase, so the first new step comes `period` base ticks after the write.
- R3: A period field of zero gives the same spacing as a period of one: one step per base tick.
- R4: With `n` base ticks counted since the last rate write, the accumulator has grown by floor(n/period) × step in sixteenths. Time equals offset plus the accumulator shifted right by 4.
- R5: On a cycle with `base_tick` low, no step occurs and time does not advance.
- R6: A rate write on an edge without a step and without an offset write leaves time unchanged across that edge.
- R7: An offset write adds `adj_delta` (two's complement, modulo 2^64) to the offset. It is visible in time from the next cycle.
- R8: A strobe on an edge loads `cap_lo` with time bits 31:0 and `cap_hi` with bits 63:32, both from the value before that edge. `cap_valid` is high exactly in the cycle after a strobe. Without a strobe both words hold.
- R9: Fractional residue in the accumulator is kept across rate changes. Sub-unit steps taken under one rate add to those taken under the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Base time tick qualifier |
| rate_we | input | 1 | Rate word write enable |
| rate_wdata | input | 32 | Rate word: period[31:24], step[23:0] |
| adj_we | input | 1 | Offset correction write enable |
| adj_delta | input | 64 | Signed correction added to the offset |
| cap_strobe | input | 1 | Capture request |
| cap_valid | output | 1 | One-cycle pulse: captured words updated |
| cap_lo | output | 32 | Captured time bits 31:0 |
| cap_hi | output | 32 | Captured time bits 63:32 |

## Verification
On every cycle the assertions check four things. Time never moves while `base_tick` is low, and a rate write never moves it. Time does not decrease unless the offset was written. A strobe yields a one-cycle valid pulse and words that equal the time from before the edge, and the words hold otherwise. The exact arithmetic can only be shown by the bench scenarios, which sweep the period from zero upward against several step values. These are: how many steps fall in a given number of ticks, the phase restart on a rate write, fraction residue carried across rates, signed offset corrections, and a carry crossing from the low word into the high word.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int DEF_TIME_W = 64;
  localparam int DEF_INC_W  = 24;
  localparam int DEF_PER_W  = 8;
  localparam int DEF_FRAC_W = 4;
  localparam int DEF_WORD_W = 32;
endpackage

// File: rtl/tsc_rate_reg.sv
module tsc_rate_reg #(
  parameter int INC_W = tsc_pkg::DEF_INC_W,
  parameter int PER_W = tsc_pkg::DEF_PER_W,
  localparam int REG_W = INC_W + PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [INC_W-1:0] incr_o,
  output logic [PER_W-1:0] period_o
);
  logic [INC_W-1:0] incr_q;
  logic [PER_W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      incr_q <= '0;
      per_q  <= '0;
    end else if (we) begin
      incr_q <= wdata[INC_W-1:0];
      per_q  <= wdata[REG_W-1:INC_W];
    end
  end

  // zero period counts as one
  assign incr_o   = incr_q;
  assign period_o = (per_q == '0) ? PER_W'(1) : per_q;
endmodule

// File: rtl/tsc_phase.sv
module tsc_phase #(
  parameter int PER_W = tsc_pkg::DEF_PER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             step_o
);
  logic [PER_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q >= period - PER_W'(1));
  assign step_o = tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= wrap ? '0 : cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
  parameter int TIME_W = tsc_pkg::DEF_TIME_W,
  parameter int INC_W  = tsc_pkg::DEF_INC_W,
  parameter int FRAC_W = tsc_pkg::DEF_FRAC_W,
  localparam int ACC_W = TIME_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [INC_W-1:0]  incr,
  input  logic              adj_we,
  input  logic [TIME_W-1:0] adj_delta,
  output logic [TIME_W-1:0] time_o
);
  logic [ACC_W-1:0]  acc_q;
  logic [TIME_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      off_q <= '0;
    end else begin
      if (step)   acc_q <= acc_q + {{(ACC_W-INC_W){1'b0}}, incr};
      if (adj_we) off_q <= off_q + adj_delta;
    end
  end

  // fraction bits dropped by the slice: divide by 2**FRAC_W
  assign time_o = off_q + acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture #(
  parameter int TIME_W = tsc_pkg::DEF_TIME_W,
  parameter int WORD_W = tsc_pkg::DEF_WORD_W,
  localparam int NWORD = TIME_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [TIME_W-1:0] time_i,
  output logic [WORD_W-1:0] words_o [NWORD],
  output logic              valid_o
);
  for (genvar g = 0; g < NWORD; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      w_q <= '0;
      else if (strobe) w_q <= time_i[g*WORD_W +: WORD_W];
    end
    assign words_o[g] = w_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= strobe;
  end
endmodule

// File: rtl/tsc_timer.sv
module tsc_timer #(
  parameter int TIME_W = tsc_pkg::DEF_TIME_W,
  parameter int INC_W  = tsc_pkg::DEF_INC_W,
  parameter int PER_W  = tsc_pkg::DEF_PER_W,
  parameter int FRAC_W = tsc_pkg::DEF_FRAC_W,
  localparam int REG_W  = INC_W + PER_W,
  localparam int WORD_W = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              rate_we,
  input  logic [REG_W-1:0]  rate_wdata,
  input  logic              adj_we,
  input  logic [TIME_W-1:0] adj_delta,
  input  logic              cap_strobe,
  output logic              cap_valid,
  output logic [WORD_W-1:0] cap_lo,
  output logic [WORD_W-1:0] cap_hi
);
  logic [INC_W-1:0]  incr_w;
  logic [PER_W-1:0]  per_w;
  logic              step_w;
  logic [TIME_W-1:0] time_w;
  logic [WORD_W-1:0] words_w [2];

  tsc_rate_reg #(.INC_W(INC_W), .PER_W(PER_W)) rate_i (
    .clk(clk), .rst_n(rst_n), .we(rate_we), .wdata(rate_wdata),
    .incr_o(incr_w), .period_o(per_w)
  );

  tsc_phase #(.PER_W(PER_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .restart(rate_we),
    .period(per_w), .step_o(step_w)
  );

  tsc_accum #(.TIME_W(TIME_W), .INC_W(INC_W), .FRAC_W(FRAC_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .step(step_w), .incr(incr_w),
    .adj_we(adj_we), .adj_delta(adj_delta), .time_o(time_w)
  );

  tsc_capture #(.TIME_W(TIME_W), .WORD_W(WORD_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .strobe(cap_strobe), .time_i(time_w),
    .words_o(words_w), .valid_o(cap_valid)
  );

  assign cap_lo = words_w[0];
  assign cap_hi = words_w[1];
endmodule

// File: rtl/tsc_timer_chk.sv
module tsc_timer_chk #(
  parameter int TIME_W = 64,
  localparam int WORD_W = TIME_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base_tick,
  input logic              rate_we,
  input logic              adj_we,
  input logic              cap_strobe,
  input logic              cap_valid,
  input logic [WORD_W-1:0] cap_lo,
  input logic [WORD_W-1:0] cap_hi,
  input logic              step,
  input logic [TIME_W-1:0] cur_time
);
  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |-> !step); // R5
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick && !adj_we) |=> $stable(cur_time)); // R5
  AST_RATE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_we && !step && !adj_we) |=> $stable(cur_time)); // R6
  AST_TIME_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !adj_we |=> (cur_time >= $past(cur_time))); // R4
  AST_CAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> cap_valid); // R8
  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> !cap_valid); // R8
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> ($stable(cap_lo) && $stable(cap_hi))); // R8
  AST_CAP_SAME_INSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> ({cap_hi, cap_lo} == $past(cur_time))); // R8
endmodule

bind tsc_timer tsc_timer_chk #(.TIME_W(TIME_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_we(rate_we),
  .adj_we(adj_we), .cap_strobe(cap_strobe), .cap_valid(cap_valid),
  .cap_lo(cap_lo), .cap_hi(cap_hi), .step(step_w), .cur_time(time_w)
);

// File: tb/tsc_timer_tb_top.sv
module tsc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        rate_we = 1'b0;
  logic [31:0] rate_wdata = '0;
  logic        adj_we = 1'b0;
  logic [63:0] adj_delta = '0;
  logic        cap_strobe = 1'b0;
  logic        cap_valid;
  logic [31:0] cap_lo, cap_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [67:0] m_acc = '0;
  logic [63:0] m_off = '0;
  logic [23:0] m_inc = '0;
  int          m_per = 1;
  int          m_since = 0;

  always #2.5 clk = ~clk;

  tsc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate_we(rate_we),
    .rate_wdata(rate_wdata), .adj_we(adj_we), .adj_delta(adj_delta),
    .cap_strobe(cap_strobe), .cap_valid(cap_valid), .cap_lo(cap_lo), .cap_hi(cap_hi)
  );

  function automatic logic [63:0] m_time();
    return m_off + m_acc[67:4];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_rate(input int per, input logic [23:0] inc);
    @(negedge clk);
    rate_we = 1'b1; rate_wdata = {per[7:0], inc};
    @(negedge clk);
    rate_we = 1'b0;
    m_inc = inc; m_per = (per == 0) ? 1 : per; m_since = 0;
  endtask

  task automatic run_ticks(input int n);
    int steps;
    @(negedge clk);
    base_tick = 1'b1;
    repeat (n) @(negedge clk);
    base_tick = 1'b0;
    steps = (m_since + n) / m_per - m_since / m_per;
    m_since += n;
    m_acc = m_acc + 68'(steps) * {44'd0, m_inc};
  endtask

  task automatic adjust(input logic [63:0] d);
    @(negedge clk);
    adj_we = 1'b1; adj_delta = d;
    @(negedge clk);
    adj_we = 1'b0;
    m_off = m_off + d;
  endtask

  task automatic cap_check(input string tag);
    @(negedge clk);
    cap_strobe = 1'b1;
    @(negedge clk);
    cap_strobe = 1'b0;
    chk({tag, " R8 valid"}, {63'd0, cap_valid}, 64'd1);
    chk(tag, {cap_hi, cap_lo}, m_time());
    @(negedge clk);
    chk({tag, " R8 pulse end"}, {63'd0, cap_valid}, 64'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    int pers [5] = '{0, 1, 2, 3, 7};
    logic [23:0] incs [4] = '{24'd16, 24'd5, 24'd40, 24'h123456};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {63'd0, cap_valid}, 64'd0);
    chk("R1 words", {cap_hi, cap_lo}, 64'd0);
    run_ticks(20);
    cap_check("R1 no rate yet");

    // R2 R3 R4 sweep of period and step
    foreach (pers[p]) begin
      foreach (incs[i]) begin
        set_rate(pers[p], incs[i]);
        run_ticks(11 + pers[p]);
        cap_check($sformatf("R4 R3 per=%0d inc=%0h", pers[p], incs[i]));
      end
    end

    // R2 phase restart: ticks before a rewrite never combine with ticks after it
    set_rate(4, 24'd32);
    run_ticks(3);
    set_rate(4, 24'd32);
    run_ticks(3);
    cap_check("R2 phase restart");
    run_ticks(1);
    cap_check("R2 first step after restart");

    // R5 idle cycles do not advance
    snap = m_time();
    repeat (10) @(negedge clk);
    cap_check("R5 idle");
    chk("R5 unchanged", m_time(), snap);

    // R6 rate change keeps time
    set_rate(1, 24'd16);
    run_ticks(5);
    cap_check("R6 before");
    set_rate(2, 24'd7);
    cap_check("R6 after write");

    // R9 residue carried across rates
    set_rate(1, 24'd1);
    run_ticks(9);
    set_rate(1, 24'd8);
    run_ticks(1);
    cap_check("R9 residue");

    // R7 offset corrections
    adjust(64'd1000);
    cap_check("R7 positive");
    adjust(-64'd250);
    cap_check("R7 negative");

    // R8 carry from low word into high word
    adjust(64'h0000_0000_ffff_fffd - m_time());
    cap_check("R8 near wrap");
    set_rate(1, 24'd16);
    run_ticks(5);
    cap_check("R8 crosses words");
    chk("R8 hi word", {32'd0, cap_hi}, 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule